// File: doc/BRIEF.md
# Floating-Point Control and Status Register

This block holds the floating-point unit's control and status word and a fixed, read-only implementation word. A processor pipeline reaches both through a small move port with a five-bit register select: select 0 names the implementation word and select 31 names the control/status word. The arithmetic unit reports each operation's exception flags through a strobe. The block records them as sticky-free flags, and also records a cause field that keeps only the flags whose enables are set. A compare operation reports its result through a second strobe, and the block keeps it as the condition bit that branch logic reads.

The block drives the current rounding mode to the arithmetic unit and presents the condition bit in true and false polarity for branch-on-true and branch-on-false. When the coprocessor-usable bit from the system status is clear, a move-port access is not carried out. Instead the block raises a coprocessor-unusable fault that carries unit number 1, and leaves taking the trap to the pipeline.

Top module: `fpu_csr_unit`

## Requirements
- R1: After a synchronous active-low reset, the control/status word is 0. The rounding mode is 0 (nearest-even), cond_true is 0, cond_false is 1, and cop_fault is 0.
- R2: A read with select 0 returns 0x00000110 (implementation 1, major version 1, minor version 0). A write with select 0 changes nothing.
- R3: A write with select 31 stores wdata AND 0x0183FFFF, and the new value is visible from the cycle after the write. A read with select 31 returns the stored word, with every bit outside 0x0183FFFF reading 0.
- R4: round_mode always equals word bits 1:0, with 0 = nearest-even, 1 = toward zero, 2 = toward +infinity, 3 = toward -infinity.
- R5: On an exception strobe, flags (bits 6:2) take the raised five-bit set. Cause (bits 17:12) takes the raised set ANDed with the enables (bits 11:7), and cause bit 17 (unimplemented, weight 32) becomes 0. The flag weights are inexact 1, underflow 2, overflow 4, divide-by-zero 8, invalid 16. No other bit changes.
- R6: A compare strobe writes its result into bit 23 and changes no other bit. cond_true equals bit 23 and cond_false is its inverse.
- R7: When cop_usable is 0, a move-port access raises cop_fault with fault_unit = 1 in the next cycle, for one cycle per access. Its write is ignored and its read returns 0.
- R8: When a write to select 31 lands in the same cycle as a strobe, the strobe's fields win over the written value. The cause uses the enables held before that cycle.
- R9: A read with any select other than 0 or 31 returns 0, and a write to such a select changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cop_usable | input | 1 | Coprocessor-usable bit from system status |
| acc_valid | input | 1 | Move-port access this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_sel | input | 5 | Control register select |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, same cycle as a read access |
| exc_stb | input | 1 | Exception report strobe |
| exc_flags | input | 5 | Raised exception set |
| cmp_stb | input | 1 | Compare result strobe |
| cmp_res | input | 1 | Compare result |
| round_mode | output | 2 | Current rounding mode |
| cond_true | output | 1 | Condition bit for branch-on-true |
| cond_false | output | 1 | Inverse condition for branch-on-false |
| cop_fault | output | 1 | Coprocessor-unusable fault pulse |
| fault_unit | output | 2 | Unit number of the fault (1 while cop_fault is high) |

## Verification
Read data is combinational, so it is due in the same cycle as the read access. Writes and both strobes take effect at the next rising edge, and round_mode, cond_true and cond_false follow the stored word without further delay. The fault pulse is registered and appears one cycle after the offending access. The bench drives every stimulus on a falling edge. It samples read data shortly after driving it, and samples register-derived outputs and the fault at the falling edge that follows the updating rising edge, so every check lands in the exact cycle in which its result is due.

// File: rtl/fpu_csr_pkg.sv
// fpu_csr_pkg: shared field positions, widths and constants for the
// floating-point control/status register. Assumes a 32-bit word.
package fpu_csr_pkg;
    localparam int CSR_W    = 32;
    localparam int SEL_W    = 5;
    localparam int EXC_W    = 5;
    localparam int CAUSE_W  = 6;
    localparam int RM_W     = 2;
    localparam int RM_LO    = 0;
    localparam int FLAG_LO  = 2;
    localparam int EN_LO    = 7;
    localparam int CAUSE_LO = 12;
    localparam int COND_BIT = 23;

    localparam logic [SEL_W-1:0] SEL_IMPL = 5'd0;
    localparam logic [SEL_W-1:0] SEL_CSR  = 5'd31;

    typedef enum logic [RM_W-1:0] {
        RM_NEAREST = 2'd0,
        RM_ZERO    = 2'd1,
        RM_UP      = 2'd2,
        RM_DOWN    = 2'd3
    } round_mode_e;
endpackage

// File: rtl/fpu_csr_gate.sv
// fpu_csr_gate: decodes move-port accesses, checks the coprocessor-usable
// bit and produces the write enable and the registered fault pulse.
// Assumes one access per cycle; select decoding is exact.
module fpu_csr_gate
    import fpu_csr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cop_usable,
    input  logic             acc_valid,
    input  logic             acc_write,
    input  logic [SEL_W-1:0] acc_sel,
    output logic             wr_csr,
    output logic             rd_impl,
    output logic             rd_csr,
    output logic             fault_q
);
    logic granted;

    // Decode a granted access into its per-register actions.
    always_comb begin
        granted = acc_valid && cop_usable;
        wr_csr  = granted && acc_write && (acc_sel == SEL_CSR);
        rd_impl = granted && !acc_write && (acc_sel == SEL_IMPL);
        rd_csr  = granted && !acc_write && (acc_sel == SEL_CSR);
    end

    // Register a one-cycle fault for each access while the unit is unusable.
    always_ff @(posedge clk) begin
        if (!rst_n) fault_q <= 1'b0;
        else        fault_q <= acc_valid && !cop_usable;
    end

    // R7
    fault_after_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !cop_usable) |=> fault_q);

    // R7
    no_write_unusable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cop_usable |-> !wr_csr);
endmodule

// File: rtl/fpu_csr_store.sv
// fpu_csr_store: holds the control/status word. Applies a masked write,
// then the exception strobe (flags and cause), then the compare strobe
// (condition bit), so strobes win over a same-cycle write. Cause uses the
// enables held before the cycle.
module fpu_csr_store
    import fpu_csr_pkg::*;
#(
    parameter logic [CSR_W-1:0] WR_MASK = 32'h0183FFFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CSR_W-1:0] wr_data,
    input  logic             exc_stb,
    input  logic [EXC_W-1:0] exc_flags,
    input  logic             cmp_stb,
    input  logic             cmp_res,
    output logic [CSR_W-1:0] csr_q
);
    localparam int PAD_W = CAUSE_W - EXC_W;

    logic [CSR_W-1:0] csr_d;
    logic [EXC_W-1:0] en_now;

    // Build the next word from the write, exception and compare sources.
    always_comb begin
        en_now = csr_q[EN_LO +: EXC_W];
        csr_d  = csr_q;
        if (wr_en)
            csr_d = wr_data & WR_MASK;
        if (exc_stb) begin
            csr_d[FLAG_LO  +: EXC_W]   = exc_flags;
            csr_d[CAUSE_LO +: CAUSE_W] = {{PAD_W{1'b0}}, exc_flags & en_now};
        end
        if (cmp_stb)
            csr_d[COND_BIT] = cmp_res;
    end

    // Hold the word; reset clears it, selecting nearest-even rounding.
    always_ff @(posedge clk) begin
        if (!rst_n) csr_q <= '0;
        else        csr_q <= csr_d;
    end

    // R3
    unused_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_q & ~WR_MASK) == '0);

    // R5
    flags_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_stb |=> csr_q[FLAG_LO +: EXC_W] == $past(exc_flags));

    // R5
    cause_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_stb |=> csr_q[CAUSE_LO +: EXC_W] ==
                    ($past(exc_flags) & $past(csr_q[EN_LO +: EXC_W])));

    // R6
    cond_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_stb |=> csr_q[COND_BIT] == $past(cmp_res));

    // R6
    cmp_only_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_stb && !exc_stb && !wr_en) |=>
            (csr_q & ~(32'h1 << COND_BIT)) == ($past(csr_q) & ~(32'h1 << COND_BIT)));
endmodule

// File: rtl/fpu_csr_unit.sv
// fpu_csr_unit: top of the floating-point control/status block. Combines
// the access gate, the register store and a combinational read mux, and
// drives rounding mode, branch condition and the unusable fault.
// Assumes read data is consumed in the cycle of the read access.
module fpu_csr_unit
    import fpu_csr_pkg::*;
#(
    parameter logic [CSR_W-1:0] IMPL_ID    = 32'h00000110,
    parameter logic [CSR_W-1:0] WR_MASK    = 32'h0183FFFF,
    parameter logic [1:0]       FAULT_UNIT = 2'd1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cop_usable,
    input  logic             acc_valid,
    input  logic             acc_write,
    input  logic [SEL_W-1:0] acc_sel,
    input  logic [CSR_W-1:0] acc_wdata,
    output logic [CSR_W-1:0] acc_rdata,
    input  logic             exc_stb,
    input  logic [EXC_W-1:0] exc_flags,
    input  logic             cmp_stb,
    input  logic             cmp_res,
    output logic [RM_W-1:0]  round_mode,
    output logic             cond_true,
    output logic             cond_false,
    output logic             cop_fault,
    output logic [1:0]       fault_unit
);
    logic             wr_csr, rd_impl, rd_csr, fault_q;
    logic [CSR_W-1:0] csr_q;
    round_mode_e      rm;

    fpu_csr_gate u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .cop_usable (cop_usable),
        .acc_valid  (acc_valid),
        .acc_write  (acc_write),
        .acc_sel    (acc_sel),
        .wr_csr     (wr_csr),
        .rd_impl    (rd_impl),
        .rd_csr     (rd_csr),
        .fault_q    (fault_q)
    );

    fpu_csr_store #(.WR_MASK(WR_MASK)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_csr),
        .wr_data   (acc_wdata),
        .exc_stb   (exc_stb),
        .exc_flags (exc_flags),
        .cmp_stb   (cmp_stb),
        .cmp_res   (cmp_res),
        .csr_q     (csr_q)
    );

    // Select read data: implementation word, masked status word, or zero.
    always_comb begin
        if (rd_impl)     acc_rdata = IMPL_ID;
        else if (rd_csr) acc_rdata = csr_q & WR_MASK;
        else             acc_rdata = '0;
    end

    // Drive the rounding mode, branch conditions and fault outputs.
    always_comb begin
        rm         = round_mode_e'(csr_q[RM_LO +: RM_W]);
        round_mode = rm;
        cond_true  = csr_q[COND_BIT];
        cond_false = !csr_q[COND_BIT];
        cop_fault  = fault_q;
        fault_unit = fault_q ? FAULT_UNIT : 2'd0;
    end

    // R2
    impl_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && cop_usable && !acc_write && acc_sel == SEL_IMPL) |-> acc_rdata == IMPL_ID);

    // R7
    unusable_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !cop_usable) |-> acc_rdata == '0);

    // R7
    fault_unit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cop_fault |-> fault_unit == FAULT_UNIT);
endmodule

// File: tb/fpu_csr_unit_test.sv
module fpu_csr_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cop_usable = 1'b1;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [4:0]  acc_sel = 5'd0;
    logic [31:0] acc_wdata = 32'd0;
    logic [31:0] acc_rdata;
    logic        exc_stb = 1'b0;
    logic [4:0]  exc_flags = 5'd0;
    logic        cmp_stb = 1'b0;
    logic        cmp_res = 1'b0;
    logic [1:0]  round_mode;
    logic        cond_true, cond_false, cop_fault;
    logic [1:0]  fault_unit;

    int tests = 0;
    int fails = 0;

    localparam logic [31:0] MASK = 32'h0183FFFF;

    always #4 clk = ~clk;

    fpu_csr_unit uut (
        .clk(clk), .rst_n(rst_n), .cop_usable(cop_usable),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_sel(acc_sel),
        .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .exc_stb(exc_stb), .exc_flags(exc_flags),
        .cmp_stb(cmp_stb), .cmp_res(cmp_res),
        .round_mode(round_mode), .cond_true(cond_true), .cond_false(cond_false),
        .cop_fault(cop_fault), .fault_unit(fault_unit)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // Write one register; the new state is visible at the returned falling edge.
    task automatic do_write(input logic [4:0] sel, input logic [31:0] data);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b1; acc_sel = sel; acc_wdata = data;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    // Read one register; read data is combinational in the access cycle.
    task automatic do_read(input logic [4:0] sel, output logic [31:0] data);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b0; acc_sel = sel;
        #1 data = acc_rdata;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        do_read(5'd31, d);
        check("R1 word", d, 32'h0);
        check("R1 round_mode", {30'd0, round_mode}, 32'd0);
        check("R1 cond_true", {31'd0, cond_true}, 32'd0);
        check("R1 cond_false", {31'd0, cond_false}, 32'd1);
        check("R1 cop_fault", {31'd0, cop_fault}, 32'd0);
    endtask

    task automatic t_impl();
        logic [31:0] d;
        do_read(5'd0, d);
        check("R2 impl read", d, 32'h00000110);
        do_write(5'd0, 32'hFFFFFFFF);
        do_read(5'd31, d);
        check("R2 sel0 write ignored", d, 32'h0);
        do_read(5'd0, d);
        check("R2 impl unchanged", d, 32'h00000110);
    endtask

    task automatic t_write_mask();
        logic [31:0] d;
        do_write(5'd31, 32'hFFFFFFFF);
        do_read(5'd31, d);
        check("R3 masked all-ones", d, MASK);
        check("R6 cond_true from write", {31'd0, cond_true}, 32'd1);
        do_write(5'd31, 32'hA5A5A5A5);
        do_read(5'd31, d);
        check("R3 masked pattern", d, 32'hA5A5A5A5 & MASK);
    endtask

    task automatic t_round();
        for (int m = 0; m < 4; m++) begin
            do_write(5'd31, 32'(m));
            check("R4 round_mode", {30'd0, round_mode}, 32'(m));
        end
    endtask

    task automatic t_exception();
        logic [31:0] d;
        do_write(5'd31, 32'h00000B02);
        @(negedge clk); exc_stb = 1'b1; exc_flags = 5'b11011;
        @(negedge clk); exc_stb = 1'b0;
        do_read(5'd31, d);
        check("R5 flags and cause", d, 32'h00012B6E);
        @(negedge clk); exc_stb = 1'b1; exc_flags = 5'b00000;
        @(negedge clk); exc_stb = 1'b0;
        do_read(5'd31, d);
        check("R5 clear flags and cause", d, 32'h00000B02);
    endtask

    task automatic t_compare();
        logic [31:0] d;
        do_write(5'd31, 32'h0000F7FF);
        @(negedge clk); cmp_stb = 1'b1; cmp_res = 1'b1;
        @(negedge clk); cmp_stb = 1'b0;
        check("R6 cond_true set", {31'd0, cond_true}, 32'd1);
        check("R6 cond_false set", {31'd0, cond_false}, 32'd0);
        do_read(5'd31, d);
        check("R6 only bit 23", d, 32'h0080F7FF);
        @(negedge clk); cmp_stb = 1'b1; cmp_res = 1'b0;
        @(negedge clk); cmp_stb = 1'b0;
        check("R6 cond_false clear", {31'd0, cond_false}, 32'd1);
        do_read(5'd31, d);
        check("R6 bit 23 cleared", d, 32'h0000F7FF);
    endtask

    task automatic t_unusable();
        logic [31:0] d;
        @(negedge clk);
        cop_usable = 1'b0;
        acc_valid = 1'b1; acc_write = 1'b1; acc_sel = 5'd31; acc_wdata = 32'h00000003;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
        check("R7 fault pulse", {31'd0, cop_fault}, 32'd1);
        check("R7 fault unit", {30'd0, fault_unit}, 32'd1);
        acc_valid = 1'b1; acc_sel = 5'd0;
        #1 d = acc_rdata;
        check("R7 read returns zero", d, 32'h0);
        @(negedge clk);
        acc_valid = 1'b0;
        check("R7 fault on read", {31'd0, cop_fault}, 32'd1);
        @(negedge clk);
        check("R7 fault single pulse", {31'd0, cop_fault}, 32'd0);
        cop_usable = 1'b1;
        do_read(5'd31, d);
        check("R7 write ignored", d, 32'h0000F7FF);
    endtask

    task automatic t_priority();
        logic [31:0] d;
        do_write(5'd31, 32'h00000F80);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b1; acc_sel = 5'd31; acc_wdata = 32'h00000001;
        exc_stb = 1'b1; exc_flags = 5'b10001;
        cmp_stb = 1'b1; cmp_res = 1'b1;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0; exc_stb = 1'b0; cmp_stb = 1'b0;
        do_read(5'd31, d);
        check("R8 strobes win over write", d, 32'h00811045);
    endtask

    task automatic t_other_sel();
        logic [31:0] d;
        do_write(5'd5, 32'h00000003);
        do_read(5'd31, d);
        check("R9 other write ignored", d, 32'h00811045);
        do_read(5'd30, d);
        check("R9 other read zero", d, 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_impl();
        t_write_mask();
        t_round();
        t_exception();
        t_compare();
        t_unusable();
        t_priority();
        t_other_sel();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule